// File: doc/BRIEF.md
# Calibration Address Lookup Sequencer

This block is a memory-mapped bus master. It turns a logical calibration target into a physical calibration-bus access. The target is an interface ID, a group number, a lane number, a pin number and an intra-lane offset. To do this it follows pointers through parameter tables held in the I/O column memory. A global table yields the interface's table pointer. The interface table yields the group count and the lane and pin pointer words. The lane and pin tables yield the two translated offsets. Their sum, added to the interface's calibration window and the intra-lane offset, is the address of one read or one write.

Each level of the walk is cached together with the key that produced it. Back-to-back requests to the same interface, group, lane or pin therefore skip the table reads they already made. A request that changes a key refetches only the levels that depend on it. The memory behind the bus is outside the block.

Top module: `cal_addr_walker`

## Requirements
- R1: After reset, `done` and `error` are low and neither `avRead` nor `avWrite` is asserted.
- R2: The global table of interface `id` is scanned at `{id,24'h00E000} + 0x18 + 2*k` for slot k = 0..10, in that order. The first entry with bit 31 set and bits [27:24] equal to `id` supplies the 24-bit table pointer in bits [23:0], and the scan stops there.
- R3: If none of the 11 slots matches, the request completes with `error` high and no calibration access is made.
- R4: The group count is read from bits [7:0] at `{id,24'h00E000} + ptr + 4`. A request whose group number is not below the count completes with `error` high and no calibration access.
- R5: The pointer word is read at `{id,24'h00E000} + ptr + 8 + (count rounded down to a multiple of 4)`. Its bits [15:0] are the lane pointer and bits [31:16] the pin pointer. The lane offset is bits [23:0] at `{id,24'h00E000} + lanePtr + lane`. The pin offset is bits [23:0] at `{id,24'h00E000} + pinPtr + 2*pin`.
- R6: The calibration access goes to `{id,24'h800000} + laneOffset + pinOffset + intra`. A read returns the bus data on `rdData`. A write drives `reqWdata`.
- R7: A command holds its address and direction while `avWaitRequest` is high, a read completes only on `avReadDataValid`, and read and write are never asserted together.
- R8: A request that repeats the previous request's ID, group, lane and pin makes no table reads, only the calibration access.
- R9: A change of ID refetches every level. A change of group refetches the pointer word, lane entry and pin entry. A change of lane alone, or of pin alone, refetches only that one entry.
- R10: Each accepted request ends with `done` high for exactly one cycle. `start` is ignored until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when idle |
| reqId | input | 4 | Interface ID |
| reqGrp | input | 8 | Group number |
| reqLane | input | 4 | Lane number |
| reqPin | input | 6 | Pin number |
| reqIntra | input | 8 | Intra-lane address |
| reqWrite | input | 1 | 1 = calibration write, 0 = read |
| reqWdata | input | 32 | Write data |
| avAddress | output | 28 | Bus address |
| avRead | output | 1 | Bus read command |
| avWrite | output | 1 | Bus write command |
| avWriteData | output | 32 | Bus write data |
| avWaitRequest | input | 1 | Bus stall |
| avReadData | input | 32 | Bus read data |
| avReadDataValid | input | 1 | Bus read data valid |
| rdData | output | 32 | Calibration read result |
| done | output | 1 | Request complete pulse |
| error | output | 1 | Request failed, valid with and after done |

## Verification
Directed requests come first. The first is a cold request that needs the full walk, including an 11-read scan. Exact repeats follow, then changes of pin only, lane only and group only; the table-read count tells these apart and so exposes any cache level that is invalidated too much or too little. Separate cases cover an interface with no matching slot, a group at or past the group count, a match in slot 0, a write followed by a read-back, and a stray `start` while busy. Seeded random requests then reuse or change each key at random under random stall and read latency. The observed calibration address and data distinguish a wrong pointer field or offset scale from a wrong table position.

// File: rtl/cal_walk_pkg.sv
package cal_walk_pkg;
  localparam int ID_W   = 4;
  localparam int OFF_W  = 24;
  localparam int ADDR_W = ID_W + OFF_W;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    ST_SCAN, ST_NGRP, ST_OFFS, ST_LANE, ST_PIN, ST_CAL
  } step_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  capture;
    logic  load;
    logic  scanNext;
    step_e step;
  } dpCtl_t;

  // cache and match status back to control
  typedef struct packed {
    logic idV;
    logic ngV;
    logic offV;
    logic laneV;
    logic pinV;
    logic grpOk;
    logic scanHit;
    logic scanLast;
  } dpStat_t;
endpackage

// File: rtl/cal_walk_dp.sv
module cal_walk_dp
  import cal_walk_pkg::*;
#(
  parameter int GRP_W = 8,
  parameter int LANE_W = 4,
  parameter int PIN_W = 6,
  parameter int INTRA_W = 8,
  parameter int SCAN_SLOTS = 11,
  parameter logic [OFF_W-1:0] TBL_BASE = 24'h00E000,
  parameter logic [OFF_W-1:0] CAL_BASE = 24'h800000,
  parameter logic [7:0] SCAN_FIRST = 8'h18
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [ID_W-1:0]    reqId,
  input  logic [GRP_W-1:0]   reqGrp,
  input  logic [LANE_W-1:0]  reqLane,
  input  logic [PIN_W-1:0]   reqPin,
  input  logic [INTRA_W-1:0] reqIntra,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic [DATA_W-1:0]  avReadData,
  output logic [ADDR_W-1:0]  avAddress,
  output logic [DATA_W-1:0]  avWriteData,
  output logic [DATA_W-1:0]  rdData,
  output dpStat_t            stat
);
  localparam int IDX_W = $clog2(SCAN_SLOTS);

  logic [ID_W-1:0]    idQ;
  logic [GRP_W-1:0]   grpQ, numGrp;
  logic [LANE_W-1:0]  laneQ;
  logic [PIN_W-1:0]   pinQ;
  logic [INTRA_W-1:0] intraQ;
  logic [DATA_W-1:0]  wdataQ, rdDataQ;
  logic [OFF_W-1:0]   tblPtr, laneOff, pinOff;
  logic [15:0]        lanePtr, pinPtr;
  logic [IDX_W-1:0]   scanIdx;
  logic idV, ngV, offV, laneV, pinV;
  logic idChg, grpChg;
  logic [ADDR_W-1:0]  tblBase, calBase;

  assign idChg   = reqId != idQ;
  assign grpChg  = idChg || (reqGrp != grpQ);
  assign tblBase = {idQ, TBL_BASE};
  assign calBase = {idQ, CAL_BASE};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idQ <= '0; grpQ <= '0; laneQ <= '0; pinQ <= '0; intraQ <= '0;
      wdataQ <= '0; rdDataQ <= '0; numGrp <= '0; tblPtr <= '0;
      laneOff <= '0; pinOff <= '0; lanePtr <= '0; pinPtr <= '0;
      scanIdx <= '0;
      idV <= 1'b0; ngV <= 1'b0; offV <= 1'b0; laneV <= 1'b0; pinV <= 1'b0;
    end else begin
      if (ctl.capture) begin
        idQ <= reqId; grpQ <= reqGrp; laneQ <= reqLane; pinQ <= reqPin;
        intraQ <= reqIntra; wdataQ <= reqWdata; scanIdx <= '0;
        if (idChg) begin idV <= 1'b0; ngV <= 1'b0; end
        if (grpChg) offV <= 1'b0;
        if (grpChg || reqLane != laneQ) laneV <= 1'b0;
        if (grpChg || reqPin != pinQ) pinV <= 1'b0;
      end
      if (ctl.scanNext) scanIdx <= scanIdx + 1'b1;
      if (ctl.load) begin
        unique case (ctl.step)
          ST_SCAN: if (stat.scanHit) begin tblPtr <= avReadData[OFF_W-1:0]; idV <= 1'b1; end
          ST_NGRP: begin numGrp <= avReadData[GRP_W-1:0]; ngV <= 1'b1; end
          ST_OFFS: begin lanePtr <= avReadData[15:0]; pinPtr <= avReadData[31:16]; offV <= 1'b1; end
          ST_LANE: begin laneOff <= avReadData[OFF_W-1:0]; laneV <= 1'b1; end
          ST_PIN:  begin pinOff <= avReadData[OFF_W-1:0]; pinV <= 1'b1; end
          default: rdDataQ <= avReadData;
        endcase
      end
    end
  end

  always_comb begin
    unique case (ctl.step)
      ST_SCAN: avAddress = tblBase + ADDR_W'(SCAN_FIRST) + ADDR_W'({scanIdx, 1'b0});
      ST_NGRP: avAddress = tblBase + ADDR_W'(tblPtr) + ADDR_W'(4);
      ST_OFFS: avAddress = tblBase + ADDR_W'(tblPtr) + ADDR_W'(8)
                         + ADDR_W'({numGrp[GRP_W-1:2], 2'b00});
      ST_LANE: avAddress = tblBase + ADDR_W'(lanePtr) + ADDR_W'(laneQ);
      ST_PIN:  avAddress = tblBase + ADDR_W'(pinPtr) + ADDR_W'({pinQ, 1'b0});
      default: avAddress = calBase + ADDR_W'(laneOff) + ADDR_W'(pinOff) + ADDR_W'(intraQ);
    endcase
  end

  assign avWriteData   = wdataQ;
  assign rdData        = rdDataQ;
  assign stat.idV      = idV;
  assign stat.ngV      = ngV;
  assign stat.offV     = offV;
  assign stat.laneV    = laneV;
  assign stat.pinV     = pinV;
  assign stat.grpOk    = grpQ < numGrp;
  assign stat.scanHit  = avReadData[31] && (avReadData[27:24] == idQ);
  assign stat.scanLast = scanIdx == IDX_W'(SCAN_SLOTS - 1);

  AST_NG_NEEDS_PTR: assert property (@(posedge clk) disable iff (!rstN)
    ngV |-> idV);   // R9
  AST_OFF_NEEDS_NG: assert property (@(posedge clk) disable iff (!rstN)
    offV |-> ngV);  // R9
endmodule

// File: rtl/cal_walk_ctrl.sv
module cal_walk_ctrl
  import cal_walk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    reqWrite,
  input  logic    avWaitRequest,
  input  logic    avReadDataValid,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    avRead,
  output logic    avWrite,
  output logic    done,
  output logic    error
);
  typedef enum logic [2:0] {C_IDLE, C_DECIDE, C_CMD, C_WAIT, C_FIN} cst_e;

  cst_e  state;
  step_e stepQ, pick;
  logic  wrQ, errQ, pickErr;

  // first level still missing, in walk order
  always_comb begin
    pick = ST_CAL;
    pickErr = 1'b0;
    if (!stat.idV)        pick = ST_SCAN;
    else if (!stat.ngV)   pick = ST_NGRP;
    else if (!stat.grpOk) pickErr = 1'b1;
    else if (!stat.offV)  pick = ST_OFFS;
    else if (!stat.laneV) pick = ST_LANE;
    else if (!stat.pinV)  pick = ST_PIN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= C_IDLE; stepQ <= ST_SCAN; wrQ <= 1'b0; errQ <= 1'b0;
    end else begin
      unique case (state)
        C_IDLE: if (start) begin
          wrQ <= reqWrite; errQ <= 1'b0; state <= C_DECIDE;
        end
        C_DECIDE: begin
          stepQ <= pick;
          if (pickErr) begin errQ <= 1'b1; state <= C_FIN; end
          else state <= C_CMD;
        end
        C_CMD: if (!avWaitRequest) state <= avWrite ? C_FIN : C_WAIT;
        C_WAIT: if (avReadDataValid) begin
          if (stepQ == ST_SCAN && !stat.scanHit) begin
            if (stat.scanLast) begin errQ <= 1'b1; state <= C_FIN; end
            else state <= C_CMD;
          end else if (stepQ == ST_CAL) state <= C_FIN;
          else state <= C_DECIDE;
        end
        default: state <= C_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.step     = stepQ;
    ctl.capture  = (state == C_IDLE) && start;
    ctl.load     = (state == C_WAIT) && avReadDataValid;
    ctl.scanNext = ctl.load && stepQ == ST_SCAN && !stat.scanHit && !stat.scanLast;
    avWrite      = (state == C_CMD) && stepQ == ST_CAL && wrQ;
    avRead       = (state == C_CMD) && !avWrite;
    done         = state == C_FIN;
  end

  assign error = errQ;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (avRead || avWrite) && avWaitRequest |=> (avRead || avWrite) && $stable(avRead) && $stable(avWrite)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_CAL_NEEDS_CACHE: assert property (@(posedge clk) disable iff (!rstN)
    (avRead || avWrite) && stepQ == ST_CAL |-> stat.idV && stat.ngV && stat.offV && stat.laneV && stat.pinV); // R8
endmodule

// File: rtl/cal_addr_walker.sv
module cal_addr_walker
  import cal_walk_pkg::*;
#(
  parameter int GRP_W = 8,
  parameter int LANE_W = 4,
  parameter int PIN_W = 6,
  parameter int INTRA_W = 8,
  parameter int SCAN_SLOTS = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ID_W-1:0]    reqId,
  input  logic [GRP_W-1:0]   reqGrp,
  input  logic [LANE_W-1:0]  reqLane,
  input  logic [PIN_W-1:0]   reqPin,
  input  logic [INTRA_W-1:0] reqIntra,
  input  logic               reqWrite,
  input  logic [DATA_W-1:0]  reqWdata,
  output logic [ADDR_W-1:0]  avAddress,
  output logic               avRead,
  output logic               avWrite,
  output logic [DATA_W-1:0]  avWriteData,
  input  logic               avWaitRequest,
  input  logic [DATA_W-1:0]  avReadData,
  input  logic               avReadDataValid,
  output logic [DATA_W-1:0]  rdData,
  output logic               done,
  output logic               error
);
  dpCtl_t  ctl;
  dpStat_t stat;

  cal_walk_ctrl uCtrl (
    .clk, .rstN, .start, .reqWrite, .avWaitRequest, .avReadDataValid,
    .stat, .ctl, .avRead, .avWrite, .done, .error
  );

  cal_walk_dp #(
    .GRP_W(GRP_W), .LANE_W(LANE_W), .PIN_W(PIN_W),
    .INTRA_W(INTRA_W), .SCAN_SLOTS(SCAN_SLOTS)
  ) uDp (
    .clk, .rstN, .ctl, .reqId, .reqGrp, .reqLane, .reqPin, .reqIntra,
    .reqWdata, .avReadData, .avAddress, .avWriteData, .rdData, .stat
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (avRead || avWrite) && avWaitRequest |=> $stable(avAddress)); // R7
endmodule

// File: tb/tb_cal_addr_walker.sv
`timescale 1ns/1ps
module tb_cal_addr_walker;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, start, reqWrite, avRead, avWrite, avWaitRequest, avReadDataValid, done, error;
  logic [3:0] reqId, reqLane;
  logic [7:0] reqGrp, reqIntra;
  logic [5:0] reqPin;
  logic [31:0] reqWdata, avWriteData, avReadData, rdData;
  logic [27:0] avAddress;

  cal_addr_walker dut (.*);

  logic [31:0] mem [logic [27:0]];
  int vecs = 0, bad = 0;
  int tblReads = 0, calCnt = 0;
  logic [27:0] calAddrSeen;
  logic [31:0] calWrSeen;
  bit finished = 0;

  // bench-side cache mirror
  logic [3:0] mId = 0, mLane = 0; logic [7:0] mGrp = 0; logic [5:0] mPin = 0;
  bit mIdV = 0, mNgV = 0, mOffV = 0, mLaneV = 0, mPinV = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] memRd(logic [27:0] a);
    if (mem.exists(a)) return mem[a];
    return (32'(a) * 32'h9E3779B1) & 32'h7FFFFFFF;
  endfunction

  function automatic logic [27:0] tb(logic [3:0] id);
    return {id, 24'h00E000};
  endfunction

  // table image: ids 5 and 12 have no matching slot
  task automatic buildTables();
    for (int id = 0; id < 16; id++) begin
      logic [23:0] ptr; logic [15:0] lp, pp; logic [7:0] ng; int hit;
      ptr = 24'h200 + 24'(id) * 24'h40;
      lp  = 16'h1000 + 16'(id) * 16'h20;
      pp  = 16'h2000 + 16'(id) * 16'h100;
      ng  = 8'(2 + id % 5);
      hit = (id * 7) % 11;
      for (int j = 0; j < 11; j++) begin
        logic [31:0] e;
        if (id == 5 || id == 12) e = (j % 2) ? {4'h8, 4'(id + 1), 24'h0} : 32'h0;
        else if (j < hit) e = (j % 2) ? {4'h8, 4'(id + 3), 24'h123} : {4'h0, 4'(id), 24'h456};
        else if (j == hit) e = {4'h8, 4'(id), ptr};
        else e = {4'h8, 4'(id), 24'hBAD};
        mem[tb(4'(id)) + 28'h18 + 28'(2 * j)] = e;
      end
      mem[tb(4'(id)) + 28'(ptr) + 28'd4] = {24'h0, ng};
      mem[tb(4'(id)) + 28'(ptr) + 28'd8 + 28'({ng[7:2], 2'b00})] = {pp, lp};
      for (int l = 0; l < 16; l++)
        mem[tb(4'(id)) + 28'(lp) + 28'(l)] = {8'hC0, 24'(l * 256 + id)};
      for (int p = 0; p < 64; p++)
        mem[tb(4'(id)) + 28'(pp) + 28'(2 * p)] = {8'hD0, 24'(p * 4 + id * 65536)};
    end
  endtask

  // bus responder: random stall and read latency
  initial begin
    bit pend = 0, stall = 0, stRd = 0; int lat = 0; logic [27:0] pAddr = 0, stAddr = 0;
    avWaitRequest = 0; avReadDataValid = 0; avReadData = 0;
    forever begin
      @(negedge clk);
      if (!rstN) begin pend = 0; stall = 0; avWaitRequest = 0; avReadDataValid = 0; continue; end
      if (avRead && avWrite) check(0, "R7", "read and write together", 1, 0);
      if (stall)
        check((avRead || avWrite) && avRead == stRd && avAddress == stAddr, "R7",
              "command held under stall", 32'(avAddress), 32'(stAddr));
      avReadDataValid = 0;
      stall = 0;
      if (pend) begin
        if (lat == 0) begin avReadDataValid = 1; avReadData = memRd(pAddr); pend = 0; end
        else lat--;
        avWaitRequest = 0;
      end else if (avRead || avWrite) begin
        if ($urandom % 3 == 0) begin
          avWaitRequest = 1; stall = 1; stAddr = avAddress; stRd = avRead;
        end else begin
          avWaitRequest = 0;
          if (avAddress[23]) begin calCnt++; calAddrSeen = avAddress; end
          else tblReads++;
          if (avRead) begin pend = 1; lat = $urandom % 3; pAddr = avAddress; end
          else begin mem[avAddress] = avWriteData; calWrSeen = avWriteData; end
        end
      end else avWaitRequest = 0;
    end
  end

  task automatic runReq(logic [3:0] id, logic [7:0] grp, logic [3:0] lane, logic [5:0] pin,
                        logic [7:0] intra, bit wr, logic [31:0] wd, string readTag, bit stray = 0);
    bit gc, found = 0, expErr = 0, scanErr = 0; int reads = 0, w = 0;
    logic [23:0] ptr = 0; logic [7:0] ng; logic [31:0] pw; logic [27:0] expAddr = 0;
    // expected from the requirements
    if (id != mId) begin mIdV = 0; mNgV = 0; end
    gc = (id != mId) || (grp != mGrp);
    if (gc) mOffV = 0;
    if (gc || lane != mLane) mLaneV = 0;
    if (gc || pin != mPin) mPinV = 0;
    mId = id; mGrp = grp; mLane = lane; mPin = pin;
    for (int j = 0; j < 11 && !found; j++) begin
      logic [31:0] e = memRd(tb(id) + 28'h18 + 28'(2 * j));
      if (!mIdV) reads++;
      if (e[31] && e[27:24] == id) begin found = 1; ptr = e[23:0]; end
    end
    if (!found) begin expErr = 1; scanErr = 1; end
    else begin
      mIdV = 1;
      ng = memRd(tb(id) + 28'(ptr) + 28'd4)[7:0];
      if (!mNgV) begin reads++; mNgV = 1; end
      if (grp >= ng) expErr = 1;
      else begin
        pw = memRd(tb(id) + 28'(ptr) + 28'd8 + 28'({ng[7:2], 2'b00}));
        if (!mOffV) begin reads++; mOffV = 1; end
        if (!mLaneV) begin reads++; mLaneV = 1; end
        if (!mPinV) begin reads++; mPinV = 1; end
        expAddr = {id, 24'h800000}
                + 28'(memRd(tb(id) + 28'(pw[15:0]) + 28'(lane))[23:0])
                + 28'(memRd(tb(id) + 28'(pw[31:16]) + 28'({pin, 1'b0}))[23:0])
                + 28'(intra);
      end
    end
    // drive
    @(negedge clk);
    tblReads = 0; calCnt = 0;
    reqId = id; reqGrp = grp; reqLane = lane; reqPin = pin; reqIntra = intra;
    reqWrite = wr; reqWdata = wd; start = 1;
    @(negedge clk);
    start = 0;
    if (stray) begin // R10: start while busy
      repeat (2) @(negedge clk);
      reqId = id ^ 4'h1; reqLane = lane + 1; start = 1;
      @(negedge clk);
      start = 0; reqId = id; reqLane = lane;
    end
    while (!done && w < 3000) begin @(negedge clk); w++; end
    check(done, "R10", "done seen", done, 1);
    check(error == expErr, scanErr ? "R3" : "R4", "error flag", error, expErr);
    check(tblReads == reads, readTag, "table reads", tblReads, reads);
    check(calCnt == (expErr ? 0 : 1), "R6", "calibration accesses", calCnt, expErr ? 0 : 1);
    if (!expErr) begin
      check(calAddrSeen == expAddr, "R5", "calibration address", calAddrSeen, expAddr);
      if (wr) check(calWrSeen == wd, "R6", "write data", calWrSeen, wd);
      else check(rdData == memRd(expAddr), "R6", "read data", rdData, memRd(expAddr));
    end
    @(negedge clk);
    check(!done, "R10", "done single cycle", done, 0);
    check(!avRead && !avWrite, "R10", "idle after done", {avRead, avWrite}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; vecs++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; start = 0; reqId = 0; reqGrp = 0; reqLane = 0; reqPin = 0;
    reqIntra = 0; reqWrite = 0; reqWdata = 0;
    buildTables();
    repeat (4) @(negedge clk);
    check(!done && !error && !avRead && !avWrite, "R1", "reset outputs",
          {done, error, avRead, avWrite}, 0);
    rstN = 1;
    @(negedge clk);
    check(!done && !error && !avRead && !avWrite, "R1", "idle after reset",
          {done, error, avRead, avWrite}, 0);

    runReq(4'd3, 8'd1, 4'd2, 6'd5, 8'h10, 0, 0, "R2");          // R2 cold, last-slot match
    runReq(4'd3, 8'd1, 4'd2, 6'd5, 8'h10, 0, 0, "R8");          // R8 repeat
    runReq(4'd3, 8'd1, 4'd2, 6'd63, 8'h10, 0, 0, "R9");         // R9 pin only
    runReq(4'd3, 8'd1, 4'd15, 6'd63, 8'hFF, 0, 0, "R9");        // R9 lane only
    runReq(4'd3, 8'd0, 4'd15, 6'd63, 8'h00, 0, 0, "R9");        // R9 group only
    runReq(4'd3, 8'd0, 4'd15, 6'd63, 8'h00, 1, 32'hCAFE0123, "R8"); // R6 write
    runReq(4'd3, 8'd0, 4'd15, 6'd63, 8'h00, 0, 0, "R8");        // R6 read back
    runReq(4'd5, 8'd0, 4'd0, 6'd0, 8'h00, 0, 0, "R3");          // R3 no match
    runReq(4'd7, 8'd4, 4'd1, 6'd1, 8'h01, 0, 0, "R4");          // R4 group == count
    runReq(4'd7, 8'd3, 4'd1, 6'd1, 8'h01, 0, 0, "R4");          // R4 last valid group
    runReq(4'd0, 8'd1, 4'd9, 6'd31, 8'h44, 0, 0, "R2");         // R2 slot 0 match
    runReq(4'd0, 8'd1, 4'd9, 6'd31, 8'h44, 0, 0, "R10", 1);     // R10 stray start

    for (int n = 0; n < 250; n++) begin
      logic [3:0] id = ($urandom % 3 == 0) ? 4'($urandom) : mId;
      logic [7:0] g  = ($urandom % 2 == 0) ? 8'($urandom % 8) : mGrp;
      logic [3:0] l  = ($urandom % 2 == 0) ? 4'($urandom) : mLane;
      logic [5:0] p  = ($urandom % 2 == 0) ? 6'($urandom) : mPin;
      runReq(id, g, l, p, 8'($urandom), 1'($urandom), $urandom, "R9");
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule